// File: doc/BRIEF.md
# Synchronous Transmit Idle Filler and Line Coder

This block feeds the serial data pin of a synchronous link. A message source hands it bytes through a valid/ready handshake and marks the final byte of each message. The block sends every byte out one bit at a time, least significant bit first, advancing only on cycles where the transmit clock enable is high.

Between messages the line is never left undriven. One fill style sends a run of one bits and drops request-to-send. A new message may begin only after at least seventeen of those ones have gone out. The other fill style sends two programmable sync characters as alternating first/second pairs and keeps request-to-send high throughout. A message that shows up part-way through a pair waits for the pair to finish.

The final bit stream is either driven as plain levels or passed through an inverted transition coder, in which a zero flips the line and a one holds it. A message byte that arrives while the source has no data ready ends the message early, so the source must keep bytes flowing.

Top module: `stx_idle_tx`

## Requirements
- R1: With `fill_sync` low, every bit between messages is a one and `rts_out` is low for each such bit, except the final fill bit described in R3.
- R2: With `fill_sync` low, at least 17 consecutive fill ones (counted since reset or since the end of the previous message) go out before the first bit of a waiting message.
- R3: With `fill_sync` low, `rts_out` is already high during the last fill one before a message, and it stays high until the last bit of that message has been sent.
- R4: With `fill_sync` high, the idle line carries `sync_a` then `sync_b`, repeated, each sent least significant bit first, and `rts_out` is high in every cycle.
- R5: With `fill_sync` high, a message may start only at a pair boundary, meaning right after a `sync_b` character or straight out of reset. A byte offered during either half of a pair waits until `sync_b` has finished, and this holds even when `sync_a` equals `sync_b`.
- R6: Each byte goes out least significant bit first, one bit per cycle in which `bit_en` is high. `line_out` does not change in a cycle in which `bit_en` is low.
- R7: With `nrzi_en` low, `line_out` equals the bit being sent: 1 is high and 0 is low.
- R8: With `nrzi_en` high, a 1 bit leaves `line_out` unchanged and a 0 bit inverts it. The ones fill therefore shows as a constant level.
- R9: After reset, `line_out` is high, `msg_ready` is low, `rts_out` is low when `fill_sync` is low, and the block is between messages with no fill bits counted.
- R10: `msg_ready` is high only in a cycle where `bit_en` is high and the offered byte is taken. The byte taken with `msg_last` high is the final byte of its message, and fill follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| fill_sync | input | 1 | 0: ones fill with RTS dropped, 1: sync pair fill with RTS held |
| nrzi_en | input | 1 | 0: level coding, 1: inverted transition coding |
| sync_a | input | 8 | First character of the idle pair |
| sync_b | input | 8 | Second character of the idle pair |
| msg_valid | input | 1 | A message byte is offered |
| msg_data | input | 8 | Offered message byte |
| msg_last | input | 1 | Offered byte ends its message |
| msg_ready | output | 1 | Offered byte is taken this cycle |
| line_out | output | 1 | Coded serial data |
| rts_out | output | 1 | Request to send |

## Verification
The hardest case to reach is a message that arrives in the middle of a sync pair whose two characters are equal. When the characters match, the line looks identical whichever half is being sent, so only the start time of the message shows that the block kept track of the pair. The bench counts bits from reset and raises the byte while the first character is still going out, in both distinct-character and equal-character runs. It then expects the data exactly at the next pair boundary. The ones-fill minimum is checked twice: right after reset, and again with a second message offered the moment the first one ends.

// File: rtl/stx_pkg.sv
// Package: shared types for the synchronous transmit idle filler.
// Assumes: nothing beyond standard SystemVerilog.
package stx_pkg;

    // Sequencer states: between messages, one-bit RTS lead, message bytes
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } stx_state_e;

endpackage

// File: rtl/stx_fill_counter.sv
// Module: stx_fill_counter
// Counts consecutive ones-fill bits sent, saturating at SAT_VAL, and clears
// on any bit that is not ones fill.
// Assumes: fill_one is only meaningful in cycles where bit_en is high.
module stx_fill_counter #(
    parameter int SAT_VAL = 17,
    parameter int CNT_W   = $clog2(SAT_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             fill_one,
    output logic [CNT_W-1:0] ones_cnt
);

    localparam logic [CNT_W-1:0] SAT_CODE = CNT_W'(SAT_VAL);

    // Saturating run-length count of fill ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt <= '0;
        end else if (bit_en) begin
            if (!fill_one) begin
                ones_cnt <= '0;
            end else if (ones_cnt != SAT_CODE) begin
                ones_cnt <= ones_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stx_line_coder.sv
// Module: stx_line_coder
// Registers the outgoing bit onto the line, either as a plain level or as an
// inverted transition code (a zero flips the line, a one holds it).
// Assumes: raw_bit is valid in every cycle where bit_en is high.
module stx_line_coder (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic nrzi_en,
    input  logic raw_bit,
    output logic line_out
);

    // Line level register; high out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b1;
        end else if (bit_en) begin
            if (nrzi_en) begin
                line_out <= raw_bit ? line_out : ~line_out;
            end else begin
                line_out <= raw_bit;
            end
        end
    end

endmodule

// File: rtl/stx_sequencer.sv
// Module: stx_sequencer
// Chooses the next bit to send: a message byte, a sync character of the idle
// pair, or a fill one. It shifts characters out LSB first, tracks the half of
// the sync pair in progress and owns the RTS register for ones-fill mode.
// Assumes: the source keeps msg_valid high until msg_ready; a missing byte at
// a character boundary inside a message ends that message.
module stx_sequencer
    import stx_pkg::*;
#(
    parameter int CHAR_W   = 8,
    parameter int MIN_ONES = 17,
    parameter int CNT_W    = $clog2(MIN_ONES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fill_sync,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    input  logic              msg_valid,
    input  logic [CHAR_W-1:0] msg_data,
    input  logic              msg_last,
    input  logic [CNT_W-1:0]  ones_cnt,
    output logic              raw_bit,
    output logic              fill_one,
    output logic              rts_q,
    output logic              msg_ready
);

    localparam int               LEFT_W    = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
    localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(CHAR_W - 1);
    localparam logic [CNT_W-1:0]  LEAD_AT   = CNT_W'(MIN_ONES - 1);

    stx_state_e        state_q, state_n;
    logic [CHAR_W-1:0] shreg_q, shreg_n;
    logic [LEFT_W-1:0] left_q, left_n;
    logic              end_q, end_n;
    logic              phase_q, phase_n;
    logic              rts_n;
    logic              take;

    // Next-bit selection and next-state logic for one enabled bit time
    always_comb begin
        state_n  = state_q;
        shreg_n  = shreg_q;
        left_n   = left_q;
        end_n    = end_q;
        phase_n  = phase_q;
        rts_n    = rts_q;
        raw_bit  = 1'b1;
        fill_one = 1'b0;
        take     = 1'b0;
        if (left_q != '0) begin
            raw_bit = shreg_q[0];
            shreg_n = shreg_q >> 1;
            left_n  = left_q - 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fill_sync) begin
                        if (!phase_q && msg_valid) begin
                            take = 1'b1;
                        end else begin
                            raw_bit = phase_q ? sync_b[0] : sync_a[0];
                            shreg_n = (phase_q ? sync_b : sync_a) >> 1;
                            left_n  = LEFT_FULL;
                            phase_n = ~phase_q;
                        end
                    end else begin
                        fill_one = 1'b1;
                        phase_n  = 1'b0;
                        rts_n    = 1'b0;
                        if (msg_valid && ones_cnt >= LEAD_AT) begin
                            rts_n   = 1'b1;
                            state_n = ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    if (msg_valid) begin
                        take = 1'b1;
                    end else begin
                        fill_one = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (!end_q && msg_valid) begin
                        take = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                        if (fill_sync) begin
                            raw_bit = sync_a[0];
                            shreg_n = sync_a >> 1;
                            left_n  = LEFT_FULL;
                            phase_n = 1'b1;
                        end else begin
                            fill_one = 1'b1;
                            phase_n  = 1'b0;
                            rts_n    = 1'b0;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
            if (take) begin
                raw_bit = msg_data[0];
                shreg_n = msg_data >> 1;
                left_n  = LEFT_FULL;
                end_n   = msg_last;
                rts_n   = 1'b1;
                state_n = ST_DATA;
            end
        end
    end

    // Handshake strobe: byte consumed in this enabled bit time
    assign msg_ready = bit_en & take;

    // Sequencer registers advance once per enabled bit time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
            end_q   <= 1'b0;
            phase_q <= 1'b0;
            rts_q   <= 1'b0;
        end else if (bit_en) begin
            state_q <= state_n;
            shreg_q <= shreg_n;
            left_q  <= left_n;
            end_q   <= end_n;
            phase_q <= phase_n;
            rts_q   <= rts_n;
        end
    end

endmodule

// File: rtl/stx_idle_tx.sv
// Module: stx_idle_tx (top)
// Synchronous transmitter back end: serializes message bytes, fills gaps with
// ones or sync pairs, drives request-to-send and codes the line.
// Assumes: one bit per cycle with bit_en high; the mode inputs change only
// between messages.
module stx_idle_tx #(
    parameter int CHAR_W   = 8,
    parameter int MIN_ONES = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fill_sync,
    input  logic              nrzi_en,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    input  logic              msg_valid,
    input  logic [CHAR_W-1:0] msg_data,
    input  logic              msg_last,
    output logic              msg_ready,
    output logic              line_out,
    output logic              rts_out
);

    localparam int CNT_W = $clog2(MIN_ONES + 1);

    logic [CNT_W-1:0] ones_cnt;
    logic             raw_bit;
    logic             fill_one;
    logic             rts_q;

    stx_sequencer #(
        .CHAR_W  (CHAR_W),
        .MIN_ONES(MIN_ONES),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .fill_sync(fill_sync),
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .msg_valid(msg_valid),
        .msg_data (msg_data),
        .msg_last (msg_last),
        .ones_cnt (ones_cnt),
        .raw_bit  (raw_bit),
        .fill_one (fill_one),
        .rts_q    (rts_q),
        .msg_ready(msg_ready)
    );

    stx_fill_counter #(
        .SAT_VAL(MIN_ONES),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .fill_one(fill_one),
        .ones_cnt(ones_cnt)
    );

    stx_line_coder u_coder (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .nrzi_en (nrzi_en),
        .raw_bit (raw_bit),
        .line_out(line_out)
    );

    // Sync-pair fill keeps RTS up; ones fill uses the sequencer's register
    assign rts_out = fill_sync | rts_q;

endmodule

// File: rtl/stx_idle_tx_chk.sv
// Module: stx_idle_tx_chk
// Checker bound to stx_idle_tx: relates the sequencer, counter and coder.
// Assumes: reset is asserted at time zero.
module stx_idle_tx_chk #(
    parameter int MIN_ONES = 17,
    parameter int CNT_W    = $clog2(MIN_ONES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             nrzi_en,
    input logic             fill_sync,
    input logic             msg_ready,
    input logic             line_out,
    input logic             raw_bit,
    input logic             fill_one,
    input logic             rts_q,
    input logic [CNT_W-1:0] ones_cnt
);

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_out));

    // R7
    nrz_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !nrzi_en) |=> line_out == $past(raw_bit));

    // R8
    nrzi_zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && nrzi_en && !raw_bit) |=> line_out != $past(line_out));

    // R8
    nrzi_fill_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && nrzi_en && fill_one) |=> $stable(line_out));

    // R2
    min_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_sync && $rose(rts_q)) |-> ones_cnt >= CNT_W'(MIN_ONES));

    // R10
    ready_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> bit_en);

endmodule

bind stx_idle_tx stx_idle_tx_chk #(
    .MIN_ONES(MIN_ONES),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .nrzi_en  (nrzi_en),
    .fill_sync(fill_sync),
    .msg_ready(msg_ready),
    .line_out (line_out),
    .raw_bit  (raw_bit),
    .fill_one (fill_one),
    .rts_q    (rts_q),
    .ones_cnt (ones_cnt)
);

// File: tb/stx_idle_tx_bench.sv
module stx_idle_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       run_en = 1'b0;
    logic       fill_sync = 1'b0;
    logic       nrzi_en = 1'b0;
    logic [7:0] sync_a = 8'h16;
    logic [7:0] sync_b = 8'h96;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_data = 8'h00;
    logic       msg_last = 1'b0;
    logic       msg_ready;
    logic       line_out;
    logic       rts_out;

    typedef struct {
        logic  bval;
        logic  rts;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   bitno = 0;
    logic prev_line = 1'b1;

    always #2 clk = ~clk;

    stx_idle_tx u_stx_idle_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_sync(fill_sync),
        .nrzi_en(nrzi_en), .sync_a(sync_a), .sync_b(sync_b),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_last(msg_last),
        .msg_ready(msg_ready), .line_out(line_out), .rts_out(rts_out)
    );

    // Bit enable every second cycle while running
    initial forever begin
        @(negedge clk);
        bit_en = run_en ? ~bit_en : 1'b0;
    end

    // Monitor: decode each sent bit and compare with the scoreboard queue
    initial forever begin
        @(posedge clk);
        if (rst_n && bit_en) begin
            logic got;
            #1;
            got = nrzi_en ? (line_out == prev_line) : line_out;
            prev_line = line_out;
            bitno++;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (got !== e.bval || rts_out !== e.rts) begin
                    errors++;
                    $display("FAIL %s bit %0d: actual bit=%b rts=%b expected bit=%b rts=%b",
                             e.req, bitno - 1, got, rts_out, e.bval, e.rts);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic push_bits(input int n, input logic v, input logic r, input string req);
        for (int i = 0; i < n; i++) exp_q.push_back('{v, r, req});
    endtask

    task automatic push_byte(input logic [7:0] b, input logic r, input string req);
        for (int i = 0; i < 8; i++) exp_q.push_back('{b[i], r, req});
    endtask

    task automatic do_reset(input logic fs, input logic nz);
        run_en = 1'b0;
        rst_n = 1'b0;
        fill_sync = fs;
        nrzi_en = nz;
        msg_valid = 1'b0;
        repeat (4) @(negedge clk);
        exp_q.delete();
        bitno = 0;
        prev_line = 1'b1;
        rst_n = 1'b1;
        #1;
        // R9: reset state at the ports
        check("R9 line", line_out, 1'b1);
        check("R9 ready", msg_ready, 1'b0);
        check("R9 rts", rts_out, fs);
        run_en = 1'b1;
    endtask

    // Driver: offer bytes one at a time until each is taken
    task automatic send_msg(input logic [7:0] bytes[$]);
        for (int i = 0; i < bytes.size(); i++) begin
            @(negedge clk);
            msg_valid = 1'b1;
            msg_data = bytes[i];
            msg_last = (i == bytes.size() - 1);
            #1;
            while (!msg_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            #1;
            msg_valid = 1'b0;
            msg_last = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        while (bitno < n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] m1[$];
        logic [7:0] m2[$];

        // Ones fill, NRZ: two messages back to back (R1 R2 R3 R6 R7 R10)
        do_reset(1'b0, 1'b0);
        push_bits(16, 1'b1, 1'b0, "R2 ones before msg");
        push_bits(1, 1'b1, 1'b1, "R3 rts lead");
        push_byte(8'hA5, 1'b1, "R6 lsb first");
        push_byte(8'h3C, 1'b1, "R10 last byte");
        push_bits(16, 1'b1, 1'b0, "R1 ones gap rts low");
        push_bits(1, 1'b1, 1'b1, "R3 rts lead");
        push_byte(8'h0F, 1'b1, "R7 nrz data");
        push_bits(12, 1'b1, 1'b0, "R1 ones after msg");
        m1 = '{8'hA5, 8'h3C};
        m2 = '{8'h0F};
        send_msg(m1);
        send_msg(m2);
        drain();

        // Ones fill, NRZI (R8 R2)
        do_reset(1'b0, 1'b1);
        push_bits(16, 1'b1, 1'b0, "R8 nrzi flat fill");
        push_bits(1, 1'b1, 1'b1, "R3 rts lead");
        push_byte(8'h81, 1'b1, "R8 nrzi data");
        push_bits(20, 1'b1, 1'b0, "R8 nrzi flat fill");
        m1 = '{8'h81};
        send_msg(m1);
        drain();

        // Sync pairs, distinct characters, message offered mid pair (R4 R5)
        do_reset(1'b1, 1'b0);
        sync_a = 8'h16;
        sync_b = 8'h96;
        push_byte(8'h16, 1'b1, "R4 sync_a");
        push_byte(8'h96, 1'b1, "R4 sync_b");
        push_byte(8'h16, 1'b1, "R5 pair held");
        push_byte(8'h96, 1'b1, "R5 pair held");
        push_byte(8'h5A, 1'b1, "R5 msg at boundary");
        push_byte(8'hE1, 1'b1, "R10 last byte");
        push_byte(8'h16, 1'b1, "R4 sync_a after msg");
        push_byte(8'h96, 1'b1, "R4 sync_b after msg");
        wait_bits(20);
        m1 = '{8'h5A, 8'hE1};
        send_msg(m1);
        drain();

        // Sync pairs, equal characters, NRZI, offered in first half (R5 R8)
        do_reset(1'b1, 1'b1);
        sync_a = 8'h7E;
        sync_b = 8'h7E;
        push_byte(8'h7E, 1'b1, "R5 equal sync first");
        push_byte(8'h7E, 1'b1, "R5 equal sync second");
        push_byte(8'hC3, 1'b1, "R5 msg at boundary");
        push_byte(8'h7E, 1'b1, "R4 sync after msg");
        push_byte(8'h7E, 1'b1, "R4 sync after msg");
        wait_bits(2);
        m1 = '{8'hC3};
        send_msg(m1);
        drain();

        // R6: no line change while bit_en is held low
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        begin
            logic held;
            held = line_out;
            repeat (6) @(negedge clk);
            check("R6 hold without enable", line_out, held);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule